// File: doc/BRIEF.md
# Piece-wise Linear Packet Buffer Allocator

This block decides where each incoming packet is placed in a DRAM packet buffer. Space is granted in whole cells. The cells come from a fixed set of pages, and consecutive grants are placed back to back inside the page that was opened most recently. Packets that arrive close together therefore tend to share DRAM rows. A request gives the packet length in bytes and is served in the same cycle. The response is a cell address made of a page index and a cell offset. When a new page is needed and none is free, the request is held off.

The departure side reports the address of each packet that leaves, together with the number of cells it held. Every page has a count of released cells. When a page is given up because the next packet does not fit in it, its unused tail is also credited as released. A page goes back to the tail of the free pool in the same cycle its count reaches a full page, without waiting for any sweep or wrap-around.

Top module: `pktbuf_page_alloc`

## Requirements
- R1: After reset the free pool holds every page in ascending index order, allocReady is high, and the first grant is page 0, cell 0.
- R2: A grant takes ceil(allocLen/CELL_BYTES) cells. A length of zero takes one cell, and a length above one page takes exactly one page (PAGE_CELLS cells).
- R3: A grant that fits in the remaining space of the current page is placed at the frontier, which is the previous grant's address plus that grant's cell count.
- R4: A grant that does not fit, or that arrives when no page is open, takes the page at the head of the free pool (first in, first out) at cell offset 0. The unused cells of the page it replaces are never handed out.
- R5: A grant that fills the current page to exactly PAGE_CELLS closes that page, so the next grant opens a new page.
- R6: A free adds freeCells to the count of the page given by the upper bits of freeAddr. A page whose count reaches PAGE_CELLS joins the tail of the pool in that cycle. Abandoned tail cells are credited when the page is given up.
- R7: A page that is still open for allocation never returns to the pool, even when every cell granted from it has been freed.
- R8: When a new page is needed and the pool is empty, allocReady is low and the frontier and open page do not change. A grant proceeds once a page returns.
- R9: When a free and a page replacement complete two different pages in the same cycle, both pages join the pool: the freed page first, then the replaced page.
- R10: allocAddr is {page index, cell offset}, with the cell offset in the low log2(PAGE_CELLS) bits. freeAddr uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocation request |
| allocLen | input | LEN_W | Packet length in bytes |
| allocReady | output | 1 | Request can be granted this cycle |
| allocAddr | output | ADDR_W | Granted cell address {page, offset} |
| freeValid | input | 1 | Departure report |
| freeAddr | input | ADDR_W | Cell address of the departing packet |
| freeCells | input | CNT_W | Cells held by the departing packet |

## Verification
The bench builds the block with four pages of 32 cells of 64 bytes. With so few pages the pool runs dry after a handful of packets, which brings the stall and its release within reach of a short run. The small pool also makes pages recycle quickly, so the first-in-first-out order of returned pages is visible. It also allows a page replacement and a departure to complete two pages in one cycle.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  // Strobes from the frontier control to the page ledger.
  typedef struct packed {
    logic take;    // pop the pool head as the new open page
    logic retire;  // credit the open page's unused tail
  } ctlStrobe_t;
endpackage

// File: rtl/alloc_frontier.sv
module alloc_frontier
  import alloc_pkg::*;
#(
  parameter int CELL_BYTES = 64,
  parameter int PAGE_CELLS = 32,
  parameter int NUM_PAGES  = 16,
  parameter int LEN_W      = 16,
  localparam int OFF_W  = $clog2(PAGE_CELLS),
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int CNT_W  = OFF_W + 1,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [LEN_W-1:0]  allocLen,
  input  logic [PAGE_W-1:0] poolHead,
  input  logic              poolEmpty,
  output logic              allocReady,
  output logic [ADDR_W-1:0] allocAddr,
  output ctlStrobe_t        strobe,
  output logic [PAGE_W-1:0] retirePage,
  output logic [CNT_W-1:0]  retireCells
);
  localparam int SHIFT = $clog2(CELL_BYTES);

  logic              curValid;
  logic [PAGE_W-1:0] curPage;
  logic [CNT_W-1:0]  frontOff;

  logic [LEN_W:0]    roundUp;
  logic [LEN_W:0]    cellsRaw;
  logic [CNT_W-1:0]  reqCells;
  logic [CNT_W:0]    frontSum;
  logic              fits;
  logic              fire;

  always_comb begin
    roundUp  = {1'b0, allocLen} + (LEN_W+1)'(CELL_BYTES - 1);
    cellsRaw = roundUp >> SHIFT;
    if (cellsRaw == '0)
      reqCells = CNT_W'(1);
    else if (cellsRaw > (LEN_W+1)'(PAGE_CELLS))
      reqCells = CNT_W'(PAGE_CELLS);
    else
      reqCells = cellsRaw[CNT_W-1:0];
  end

  assign frontSum   = {1'b0, frontOff} + {1'b0, reqCells};
  assign fits       = curValid && (frontSum <= (CNT_W+1)'(PAGE_CELLS));
  assign allocReady = fits || !poolEmpty;
  assign fire       = allocValid && allocReady;
  assign allocAddr  = fits ? {curPage, frontOff[OFF_W-1:0]} : {poolHead, {OFF_W{1'b0}}};

  assign strobe.take   = fire && !fits;
  assign strobe.retire = fire && !fits && curValid;
  assign retirePage    = curPage;
  assign retireCells   = CNT_W'(PAGE_CELLS) - frontOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curValid <= 1'b0;
      curPage  <= '0;
      frontOff <= '0;
    end else if (fire) begin
      if (fits) begin
        frontOff <= frontSum[CNT_W-1:0];
        if (frontSum == (CNT_W+1)'(PAGE_CELLS)) curValid <= 1'b0;
      end else begin
        curPage  <= poolHead;
        frontOff <= reqCells;
        curValid <= (reqCells != CNT_W'(PAGE_CELLS));
      end
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && !allocReady) |=> ($stable(curPage) && $stable(frontOff) && $stable(curValid)));

  // R4
  page_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> !poolEmpty);

  // R3
  front_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    curValid |-> (frontOff < CNT_W'(PAGE_CELLS)));
endmodule

// File: rtl/page_ledger.sv
module page_ledger
  import alloc_pkg::*;
#(
  parameter int PAGE_CELLS = 32,
  parameter int NUM_PAGES  = 16,
  localparam int OFF_W  = $clog2(PAGE_CELLS),
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int CNT_W  = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [PAGE_W-1:0] retirePage,
  input  logic [CNT_W-1:0]  retireCells,
  input  logic              freeValid,
  input  logic [PAGE_W-1:0] freePage,
  input  logic [CNT_W-1:0]  freeCells,
  output logic [PAGE_W-1:0] poolHead,
  output logic              poolEmpty
);
  logic [NUM_PAGES-1:0] pageFull;

  for (genvar gp = 0; gp < NUM_PAGES; gp++) begin : g_page
    logic [CNT_W-1:0] relCnt;
    logic [CNT_W:0]   addFree;
    logic [CNT_W:0]   addRetire;
    logic [CNT_W:0]   nxtCnt;

    assign addFree   = (freeValid && freePage == PAGE_W'(gp)) ? {1'b0, freeCells} : '0;
    assign addRetire = (strobe.retire && retirePage == PAGE_W'(gp)) ? {1'b0, retireCells} : '0;
    assign nxtCnt    = {1'b0, relCnt} + addFree + addRetire;
    assign pageFull[gp] = (nxtCnt == (CNT_W+1)'(PAGE_CELLS));

    always_ff @(posedge clk) begin
      if (!rstN)             relCnt <= '0;
      else if (pageFull[gp]) relCnt <= '0;
      else                   relCnt <= nxtCnt[CNT_W-1:0];
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      nxtCnt <= (CNT_W+1)'(PAGE_CELLS));
  end

  function automatic logic [PAGE_W-1:0] stepPtr(input logic [PAGE_W-1:0] p);
    return (p == PAGE_W'(NUM_PAGES - 1)) ? '0 : p + PAGE_W'(1);
  endfunction

  logic [PAGE_W-1:0] poolMem [NUM_PAGES];
  logic [PAGE_W-1:0] rdPtr;
  logic [PAGE_W-1:0] wrPtr;
  logic [PAGE_W:0]   poolCnt;
  logic              pushFree;
  logic              pushRetire;
  logic [PAGE_W-1:0] wrPtr2;

  assign pushFree   = freeValid && pageFull[freePage];
  assign pushRetire = strobe.retire && pageFull[retirePage]
                      && !(freeValid && freePage == retirePage);
  assign wrPtr2     = pushFree ? stepPtr(wrPtr) : wrPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PAGES; i++) poolMem[i] <= PAGE_W'(i);
      rdPtr   <= '0;
      wrPtr   <= '0;
      poolCnt <= (PAGE_W+1)'(NUM_PAGES);
    end else begin
      if (pushFree)   poolMem[wrPtr]  <= freePage;
      if (pushRetire) poolMem[wrPtr2] <= retirePage;
      if (pushRetire) wrPtr <= stepPtr(wrPtr2);
      else            wrPtr <= wrPtr2;
      if (strobe.take) rdPtr <= stepPtr(rdPtr);
      poolCnt <= poolCnt + (PAGE_W+1)'(pushFree) + (PAGE_W+1)'(pushRetire)
                 - (PAGE_W+1)'(strobe.take);
    end
  end

  assign poolHead  = poolMem[rdPtr];
  assign poolEmpty = (poolCnt == '0);

  // R6
  pool_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    poolCnt <= (PAGE_W+1)'(NUM_PAGES));

  // R9
  dual_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushFree && pushRetire) |=>
      (int'(poolCnt) == int'($past(poolCnt)) + 2 - int'($past(strobe.take))));
endmodule

// File: rtl/pktbuf_page_alloc.sv
module pktbuf_page_alloc
  import alloc_pkg::*;
#(
  parameter int CELL_BYTES = 64,
  parameter int PAGE_CELLS = 32,
  parameter int NUM_PAGES  = 16,
  parameter int LEN_W      = 16,
  localparam int OFF_W  = $clog2(PAGE_CELLS),
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int CNT_W  = OFF_W + 1,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [LEN_W-1:0]  allocLen,
  output logic              allocReady,
  output logic [ADDR_W-1:0] allocAddr,
  input  logic              freeValid,
  input  logic [ADDR_W-1:0] freeAddr,
  input  logic [CNT_W-1:0]  freeCells
);
  ctlStrobe_t        strobe;
  logic [PAGE_W-1:0] retirePage;
  logic [CNT_W-1:0]  retireCells;
  logic [PAGE_W-1:0] poolHead;
  logic              poolEmpty;

  alloc_frontier #(
    .CELL_BYTES(CELL_BYTES), .PAGE_CELLS(PAGE_CELLS),
    .NUM_PAGES(NUM_PAGES), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocLen(allocLen),
    .poolHead(poolHead), .poolEmpty(poolEmpty),
    .allocReady(allocReady), .allocAddr(allocAddr),
    .strobe(strobe), .retirePage(retirePage), .retireCells(retireCells)
  );

  page_ledger #(
    .PAGE_CELLS(PAGE_CELLS), .NUM_PAGES(NUM_PAGES)
  ) u_ledger (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .retirePage(retirePage), .retireCells(retireCells),
    .freeValid(freeValid), .freePage(freeAddr[ADDR_W-1:OFF_W]), .freeCells(freeCells),
    .poolHead(poolHead), .poolEmpty(poolEmpty)
  );
endmodule

// File: tb/sim_pktbuf_page_alloc.sv
module sim_pktbuf_page_alloc;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              allocValid = 1'b0;
  logic [15:0]       allocLen = '0;
  logic              allocReady;
  logic [ADDR_W-1:0] allocAddr;
  logic              freeValid = 1'b0;
  logic [ADDR_W-1:0] freeAddr = '0;
  logic [CNT_W-1:0]  freeCells = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int    expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  pktbuf_page_alloc #(.CELL_BYTES(64), .PAGE_CELLS(32), .NUM_PAGES(4), .LEN_W(16)) u0 (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocLen(allocLen),
    .allocReady(allocReady), .allocAddr(allocAddr),
    .freeValid(freeValid), .freeAddr(freeAddr), .freeCells(freeCells)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: compares every expected grant at the falling edge.
  always @(negedge clk) begin
    if (rstN && allocValid && expQ.size() > 0) begin
      int    e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(allocReady == 1'b1, {t, " ready"}, int'(allocReady), 1);
      check(int'(allocAddr) == e, {t, " addr"}, int'(allocAddr), e);
    end
  end

  task automatic allocPkt(input int len, input int expAddr, input string tag);
    expQ.push_back(expAddr);
    tagQ.push_back(tag);
    allocLen   = 16'(len);
    allocValid = 1'b1;
    @(posedge clk); #1;
    allocValid = 1'b0;
  endtask

  task automatic freePkt(input int addr, input int cells);
    freeAddr  = ADDR_W'(addr);
    freeCells = CNT_W'(cells);
    freeValid = 1'b1;
    @(posedge clk); #1;
    freeValid = 1'b0;
  endtask

  task automatic allocFree(input int len, input int expAddr, input string tag,
                           input int addr, input int cells);
    expQ.push_back(expAddr);
    tagQ.push_back(tag);
    allocLen   = 16'(len);
    allocValid = 1'b1;
    freeAddr   = ADDR_W'(addr);
    freeCells  = CNT_W'(cells);
    freeValid  = 1'b1;
    @(posedge clk); #1;
    allocValid = 1'b0;
    freeValid  = 1'b0;
  endtask

  task automatic expectStall(input int len, input string tag);
    allocLen   = 16'(len);
    allocValid = 1'b1;
    @(negedge clk);
    check(allocReady == 1'b0, tag, int'(allocReady), 0);
    @(posedge clk); #1;
    allocValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(allocReady == 1'b1, "R1 ready after reset", int'(allocReady), 1);
    @(posedge clk); #1;

    allocPkt(100,  0,  "R1 first grant page0");
    allocPkt(64,   2,  "R3 contiguous");
    allocPkt(0,    3,  "R2 zero length");
    allocPkt(65,   4,  "R2 round up");
    allocPkt(3000, 32, "R4 clipped to page, new page1");
    allocPkt(1920, 64, "R5 closed page, new page2");
    allocPkt(200,  96, "R4 no fit, page3");
    freePkt(0, 2);
    freePkt(2, 1);
    freePkt(3, 1);
    expectStall(2048, "R8 stall when pool empty");
    freePkt(4, 2);
    allocPkt(1792, 100, "R8 frontier kept across stall");
    allocPkt(64,   0,   "R6 page0 recycled");
    freePkt(0, 1);
    freePkt(32, 32);
    freePkt(64, 30);
    allocPkt(2048, 32, "R7 open page0 not returned");
    allocPkt(1,    64, "R6 FIFO order page2");
    allocPkt(2048, 0,  "R6 abandoned tail credited page0");
    freePkt(96, 4);
    freePkt(100, 28);
    allocPkt(64, 96, "R10 page3 offset0");
    freePkt(96, 1);
    freePkt(32, 32);
    allocFree(2048, 32, "R9 replace page3 with page1", 64, 1);
    allocPkt(64,   64, "R9 freed page first");
    allocPkt(2048, 96, "R9 replaced page second");

    @(negedge clk);
    check(expQ.size() == 0, "R1 all grants observed", expQ.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule